// File: doc/BRIEF.md
# I2C slave address recognition unit

This block sits on an I2C bus as a slave and handles the opening of a transaction. It samples SCL and SDA with the system clock and finds START, repeated START and STOP conditions. It assembles the bytes that follow and compares the address bytes against a 7-bit or 10-bit own address. The block pulls either line low through two open-drain enables. It answers the acknowledge slot on its own, or it stretches the clock and lets a host decide the answer.

The address can be checked in hardware, or every byte can be handed to the host, and one configuration bit picks the mode. In hardware mode the block recognises its own address, the all-zero general call and the start byte, and it raises status flags and a one-cycle interrupt pulse. After a write match, the data bytes that follow land in a receive register. The host can turn on host-decided mode at any byte boundary, for example after a general call, so that it judges each later byte itself.

Top module: `i2c_addr_match`

## Requirements
- R1: A falling SDA while SCL is high (START) starts address reception at bit 0 and clears `addr_match` and `gen_call`. A rising SDA while SCL is high (STOP) returns the block to idle. Bytes clocked after a STOP and before the next START get no acknowledge and raise no interrupt.
- R2: SDA is sampled on the rising edge of SCL, most significant bit first. The block changes `sda_oe` only while SCL is low.
- R3: In 7-bit mode (`cfg_ten_bit`=0), a first byte whose bits 7..1 equal `cfg_own_addr[6:0]` sets `addr_match`, loads bit 0 into `rd_flag` and pulses `irq` once. With `cfg_nak`=0 the block holds SDA low during the ninth clock.
- R4: On a hardware address match with `cfg_nak`=1, `addr_match` is still set, but SDA stays released in the ninth clock.
- R5: An address that matches nothing sets no flag and gets no acknowledge, and the block ignores every byte after it until the next START or STOP.
- R6: In 10-bit mode the first byte must equal 11110, `cfg_own_addr[9:8]`, 0. It is then acknowledged without setting `addr_match`. A second byte equal to `cfg_own_addr[7:0]` sets `addr_match` and is acknowledged. A wrong first or second byte is not acknowledged and leaves `addr_match` clear.
- R7: After a full 10-bit write match and before a STOP, a repeated START followed by 11110, `cfg_own_addr[9:8]`, 1 sets `addr_match` and `rd_flag` and is acknowledged. The same byte after a STOP is refused.
- R8: With `cfg_gc_en`=1, the byte 0x00 sets `addr_match` and `gen_call`, clears `rd_flag` and is acknowledged according to `cfg_nak`, in both 7-bit and 10-bit mode. With `cfg_gc_en`=0 the byte 0x00 is refused and sets no flag.
- R9: With `cfg_gc_en`=1, the byte 0x01 (start byte) sets `addr_match`, `gen_call` and `rd_flag` and is never acknowledged, even with `cfg_nak`=0.
- R10: With `cfg_sw_recog`=1 at the end of a byte, that byte sets `rx_full` and is placed on `rx_byte`, and neither `addr_match` nor `gen_call` is set. A first address byte still loads its bit 0 into `rd_flag`. After the eighth SCL fall the block holds SCL low until a `ctl_wr` pulse. It then drives SDA low if `cfg_nak`=0, or leaves SDA released if `cfg_nak`=1, and releases SCL.
- R11: After an acknowledged hardware write match, each data byte sets `rx_full`, appears on `rx_byte` and is acknowledged according to `cfg_nak` (or by the host if `cfg_sw_recog` is set). A `ctl_wr` pulse clears `rx_full`.
- R12: A START in the middle of a byte discards the partial bits, and the next eight bits form a fresh first address byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that oversamples the bus |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_i | input | 1 | SCL line level |
| sda_i | input | 1 | SDA line level |
| cfg_own_addr | input | 10 | Own address; bits 6..0 in 7-bit mode, all ten in 10-bit mode |
| cfg_ten_bit | input | 1 | 1 selects 10-bit addressing |
| cfg_gc_en | input | 1 | 1 enables general call and start byte recognition |
| cfg_sw_recog | input | 1 | 1 hands every byte to the host with clock stretching |
| cfg_nak | input | 1 | Acknowledge answer: 0 acknowledges, 1 refuses |
| ctl_wr | input | 1 | One-cycle host write pulse: ends a stretch and clears `rx_full` |
| scl_oe | output | 1 | 1 pulls SCL low |
| sda_oe | output | 1 | 1 pulls SDA low |
| addr_match | output | 1 | Hardware address match flag |
| gen_call | output | 1 | General call or start byte seen |
| rd_flag | output | 1 | R/W bit of the last first-address byte |
| rx_full | output | 1 | A byte waits on `rx_byte` |
| rx_byte | output | 8 | Last byte handed to the host |
| irq | output | 1 | One-cycle pulse when `addr_match` or `rx_full` is set |

## Verification
The bench builds the block with a three-stage input synchronizer instead of the default two and clocks the bus with 10 system clocks per quarter bit. This shows that the deeper line delay still leaves room for the acknowledge drive, the stretch and the release to fall inside a single low phase of SCL. The own address is 0x5A in 7-bit mode and 0x2B5 in 10-bit mode. With these values, one bench exercises the header and low-byte comparison, the repeated-START read and the general call in both address widths.

// File: rtl/i2c_am_pkg.sv
package i2c_am_pkg;

  localparam int unsigned BYTE_W = 8;
  localparam int unsigned ADDR_W = 10;
  localparam int unsigned HDR_W  = 5;
  localparam logic [HDR_W-1:0] TEN_HDR = 5'b11110;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_RX,
    ST_WAIT_FALL,
    ST_STRETCH,
    ST_RELEASE,
    ST_ACK,
    ST_IGNORE
  } st_e;

  typedef enum logic [1:0] {
    PH_A1,
    PH_A2,
    PH_DATA,
    PH_NONE
  } ph_e;

  typedef struct packed {
    logic ack;
    logic stretch;
    ph_e  nxt;
  } dec_t;

endpackage

// File: rtl/i2c_am_linemon.sv
module i2c_am_linemon #(
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_i,
  input  logic sda_i,
  output logic scl_s,
  output logic sda_s,
  output logic scl_rise,
  output logic scl_fall,
  output logic start_det,
  output logic stop_det
);

  localparam int unsigned N_LINES = 2;
  localparam int unsigned L_SCL   = 0;
  localparam int unsigned L_SDA   = 1;

  logic [N_LINES-1:0] raw;
  logic [N_LINES-1:0] synced;
  logic [N_LINES-1:0] prev_q;

  assign raw = {sda_i, scl_i};

  for (genvar l = 0; l < N_LINES; l++) begin : g_line
    logic [SYNC_STAGES-1:0] chain_q;
    logic [SYNC_STAGES-1:0] chain_d;

    assign chain_d = {chain_q[SYNC_STAGES-2:0], raw[l]};

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) chain_q <= '1;
      else        chain_q <= chain_d;
    end

    assign synced[l] = chain_q[SYNC_STAGES-1];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev_q <= '1;
    else        prev_q <= synced;
  end

  assign scl_s     = synced[L_SCL];
  assign sda_s     = synced[L_SDA];
  assign scl_rise  = synced[L_SCL] & ~prev_q[L_SCL];
  assign scl_fall  = ~synced[L_SCL] & prev_q[L_SCL];
  assign start_det = synced[L_SCL] & prev_q[L_SCL] & prev_q[L_SDA] & ~synced[L_SDA];
  assign stop_det  = synced[L_SCL] & prev_q[L_SCL] & ~prev_q[L_SDA] & synced[L_SDA];

endmodule

// File: rtl/i2c_am_shift.sv
module i2c_am_shift #(
  parameter int unsigned BYTE_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clr,
  input  logic              en,
  input  logic              rise,
  input  logic              sda,
  output logic [BYTE_W-1:0] byte_o,
  output logic              done
);

  localparam int unsigned CNT_W = $clog2(BYTE_W);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(BYTE_W - 1);

  logic [CNT_W-1:0]  cnt_q, cnt_d;
  logic [BYTE_W-1:0] sh_q, sh_d;
  logic              done_q, done_d;

  always_comb begin
    cnt_d  = cnt_q;
    sh_d   = sh_q;
    done_d = 1'b0;
    if (clr) begin
      cnt_d = '0;
    end else if (en && rise) begin
      sh_d = {sh_q[BYTE_W-2:0], sda};
      if (cnt_q == LAST) begin
        cnt_d  = '0;
        done_d = 1'b1;
      end else begin
        cnt_d = cnt_q + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      sh_q   <= '0;
      done_q <= 1'b0;
    end else begin
      cnt_q  <= cnt_d;
      sh_q   <= sh_d;
      done_q <= done_d;
    end
  end

  assign byte_o = sh_q;
  assign done   = done_q;

  p_done_after_rise_r2: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> $past(en && rise && !clr));

endmodule

// File: rtl/i2c_am_cmp.sv
module i2c_am_cmp
  import i2c_am_pkg::*;
#(
  parameter int unsigned A_W = ADDR_W,
  parameter int unsigned B_W = BYTE_W
) (
  input  logic [B_W-1:0] rx,
  input  logic [A_W-1:0] own,
  output logic           hit7,
  output logic           is_zero,
  output logic           hdr_hit,
  output logic           lo_hit
);

  localparam int unsigned HI_W = A_W - B_W;

  assign hit7    = (rx[B_W-1:1] == own[B_W-2:0]);
  assign is_zero = (rx[B_W-1:1] == '0);
  assign hdr_hit = (rx[B_W-1:B_W-HDR_W] == TEN_HDR) &&
                   (rx[HI_W:1] == own[A_W-1:B_W]);
  assign lo_hit  = (rx == own[B_W-1:0]);

endmodule

// File: rtl/i2c_addr_match.sv
module i2c_addr_match
  import i2c_am_pkg::*;
#(
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              scl_i,
  input  logic              sda_i,
  input  logic [ADDR_W-1:0] cfg_own_addr,
  input  logic              cfg_ten_bit,
  input  logic              cfg_gc_en,
  input  logic              cfg_sw_recog,
  input  logic              cfg_nak,
  input  logic              ctl_wr,
  output logic              scl_oe,
  output logic              sda_oe,
  output logic              addr_match,
  output logic              gen_call,
  output logic              rd_flag,
  output logic              rx_full,
  output logic [BYTE_W-1:0] rx_byte,
  output logic              irq
);

  localparam int unsigned RST_STAGES = 2;

  // reset: asserted at once, released on the clock
  logic [RST_STAGES-1:0] rst_sync_q;
  logic                  rst_n_s;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= '0;
    else        rst_sync_q <= {rst_sync_q[RST_STAGES-2:0], 1'b1};
  end
  assign rst_n_s = rst_sync_q[RST_STAGES-1];

  // bus sampling
  logic scl_s, sda_s, scl_rise, scl_fall, start_det, stop_det;

  i2c_am_linemon #(.SYNC_STAGES(SYNC_STAGES)) i_linemon (
    .clk       (clk),
    .rst_n     (rst_n_s),
    .scl_i     (scl_i),
    .sda_i     (sda_i),
    .scl_s     (scl_s),
    .sda_s     (sda_s),
    .scl_rise  (scl_rise),
    .scl_fall  (scl_fall),
    .start_det (start_det),
    .stop_det  (stop_det)
  );

  st_e  state_q, state_d;
  ph_e  phase_q, phase_d;

  logic              sh_clr, byte_done;
  logic [BYTE_W-1:0] rx_shift;

  assign sh_clr = start_det | stop_det | (state_q != ST_RX);

  i2c_am_shift #(.BYTE_W(BYTE_W)) i_shift (
    .clk    (clk),
    .rst_n  (rst_n_s),
    .clr    (sh_clr),
    .en     (state_q == ST_RX),
    .rise   (scl_rise),
    .sda    (sda_s),
    .byte_o (rx_shift),
    .done   (byte_done)
  );

  logic hit7, is_zero, hdr_hit, lo_hit;

  i2c_am_cmp #(.A_W(ADDR_W), .B_W(BYTE_W)) i_cmp (
    .rx      (rx_shift),
    .own     (cfg_own_addr),
    .hit7    (hit7),
    .is_zero (is_zero),
    .hdr_hit (hdr_hit),
    .lo_hit  (lo_hit)
  );

  // byte decision
  dec_t dec;
  logic set_match, set_gc, set_arm, set_rx, rd_upd;
  logic rd_bit;

  assign rd_bit = rx_shift[0];

  always_comb begin
    dec       = '{ack: 1'b0, stretch: 1'b0, nxt: PH_NONE};
    set_match = 1'b0;
    set_gc    = 1'b0;
    set_arm   = 1'b0;
    set_rx    = 1'b0;
    rd_upd    = 1'b0;
    if (state_q == ST_RX && byte_done) begin
      rd_upd = (phase_q == PH_A1);
      if (cfg_sw_recog) begin
        set_rx      = 1'b1;
        dec.stretch = 1'b1;
        dec.nxt     = (phase_q == PH_A1 && rd_bit) ? PH_NONE : PH_DATA;
      end else begin
        case (phase_q)
          PH_A1: begin
            if (cfg_gc_en && is_zero) begin
              set_match = 1'b1;
              set_gc    = 1'b1;
              dec.ack   = !rd_bit && !cfg_nak;
              dec.nxt   = (!rd_bit && !cfg_nak) ? PH_DATA : PH_NONE;
            end else if (!cfg_ten_bit && hit7) begin
              set_match = 1'b1;
              dec.ack   = !cfg_nak;
              dec.nxt   = (!cfg_nak && !rd_bit) ? PH_DATA : PH_NONE;
            end else if (cfg_ten_bit && hdr_hit && !rd_bit) begin
              dec.ack   = !cfg_nak;
              dec.nxt   = !cfg_nak ? PH_A2 : PH_NONE;
            end else if (cfg_ten_bit && hdr_hit && rd_bit && arm_q) begin
              set_match = 1'b1;
              dec.ack   = !cfg_nak;
              dec.nxt   = PH_NONE;
            end
          end
          PH_A2: begin
            if (lo_hit) begin
              set_match = 1'b1;
              set_arm   = 1'b1;
              dec.ack   = !cfg_nak;
              dec.nxt   = !cfg_nak ? PH_DATA : PH_NONE;
            end
          end
          PH_DATA: begin
            set_rx  = 1'b1;
            dec.ack = !cfg_nak;
            dec.nxt = !cfg_nak ? PH_DATA : PH_NONE;
          end
          default: ;
        endcase
      end
    end
  end

  // sequencer and flag registers
  logic              ack_q, ack_d;
  logic              stretch_q, stretch_d;
  ph_e               nxt_q, nxt_d;
  logic              arm_q, arm_d;
  logic              match_q, match_d;
  logic              gc_q, gc_d;
  logic              rd_q, rd_d;
  logic              rxf_q, rxf_d;
  logic [BYTE_W-1:0] rxb_q, rxb_d;
  logic              irq_q, irq_d;

  always_comb begin
    state_d   = state_q;
    phase_d   = phase_q;
    ack_d     = ack_q;
    stretch_d = stretch_q;
    nxt_d     = nxt_q;
    arm_d     = arm_q;
    match_d   = match_q;
    gc_d      = gc_q;
    rd_d      = rd_q;
    rxf_d     = rxf_q;
    rxb_d     = rxb_q;
    irq_d     = set_match | set_rx;

    case (state_q)
      ST_RX: begin
        if (byte_done) begin
          ack_d     = dec.ack;
          stretch_d = dec.stretch;
          nxt_d     = dec.nxt;
          state_d   = ST_WAIT_FALL;
        end
      end
      ST_WAIT_FALL: begin
        if (scl_fall) state_d = stretch_q ? ST_STRETCH : ST_ACK;
      end
      ST_STRETCH: begin
        if (ctl_wr) begin
          ack_d   = !cfg_nak;
          if (cfg_nak) nxt_d = PH_NONE;
          state_d = ST_RELEASE;
        end
      end
      ST_RELEASE: state_d = ST_ACK;
      ST_ACK: begin
        if (scl_fall) begin
          ack_d = 1'b0;
          if (nxt_q == PH_NONE) begin
            state_d = ST_IGNORE;
          end else begin
            state_d = ST_RX;
            phase_d = nxt_q;
          end
        end
      end
      default: ;
    endcase

    if (set_match) match_d = 1'b1;
    if (set_gc)    gc_d    = 1'b1;
    if (set_arm)   arm_d   = 1'b1;
    if (rd_upd)    rd_d    = rd_bit;
    if (ctl_wr)    rxf_d   = 1'b0;
    if (set_rx) begin
      rxf_d = 1'b1;
      rxb_d = rx_shift;
    end

    if (start_det) begin
      state_d = ST_RX;
      phase_d = PH_A1;
      ack_d   = 1'b0;
      match_d = 1'b0;
      gc_d    = 1'b0;
    end
    if (stop_det) begin
      state_d = ST_IDLE;
      ack_d   = 1'b0;
      arm_d   = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n_s) begin
    if (!rst_n_s) begin
      state_q   <= ST_IDLE;
      phase_q   <= PH_A1;
      ack_q     <= 1'b0;
      stretch_q <= 1'b0;
      nxt_q     <= PH_NONE;
      arm_q     <= 1'b0;
      match_q   <= 1'b0;
      gc_q      <= 1'b0;
      rd_q      <= 1'b0;
      rxf_q     <= 1'b0;
      rxb_q     <= '0;
      irq_q     <= 1'b0;
    end else begin
      state_q   <= state_d;
      phase_q   <= phase_d;
      ack_q     <= ack_d;
      stretch_q <= stretch_d;
      nxt_q     <= nxt_d;
      arm_q     <= arm_d;
      match_q   <= match_d;
      gc_q      <= gc_d;
      rd_q      <= rd_d;
      rxf_q     <= rxf_d;
      rxb_q     <= rxb_d;
      irq_q     <= irq_d;
    end
  end

  assign scl_oe     = (state_q == ST_STRETCH) || (state_q == ST_RELEASE);
  assign sda_oe     = ack_q && ((state_q == ST_RELEASE) || (state_q == ST_ACK));
  assign addr_match = match_q;
  assign gen_call   = gc_q;
  assign rd_flag    = rd_q;
  assign rx_full    = rxf_q;
  assign rx_byte    = rxb_q;
  assign irq        = irq_q;

  p_sda_only_scl_low_r2: assert property (@(posedge clk) disable iff (!rst_n_s)
    !$stable(sda_oe) |-> !scl_s);

  p_irq_on_match_r3: assert property (@(posedge clk) disable iff (!rst_n_s)
    $rose(addr_match) |-> irq);

  p_gc_has_match_r8: assert property (@(posedge clk) disable iff (!rst_n_s)
    gen_call |-> addr_match);

  p_start_byte_nack_r9: assert property (@(posedge clk) disable iff (!rst_n_s)
    (gen_call && rd_flag && !cfg_sw_recog && state_q == ST_ACK && !stretch_q) |-> !sda_oe);

  p_stretch_hold_r10: assert property (@(posedge clk) disable iff (!rst_n_s)
    (state_q == ST_STRETCH && !ctl_wr) |=> scl_oe);

endmodule

// File: tb/test_i2c_addr_match.sv
module test_i2c_addr_match;

  localparam int Q = 10;

  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic       rst_n;
  logic       scl_m, sda_m;
  logic [9:0] cfg_own_addr;
  logic       cfg_ten_bit, cfg_gc_en, cfg_sw_recog, cfg_nak, ctl_wr;
  logic       scl_oe, sda_oe, addr_match, gen_call, rd_flag, rx_full, irq;
  logic [7:0] rx_byte;

  wire scl_bus = scl_m & ~scl_oe;
  wire sda_bus = sda_m & ~sda_oe;

  i2c_addr_match #(.SYNC_STAGES(3)) i_i2c_addr_match (
    .clk          (clk),
    .rst_n        (rst_n),
    .scl_i        (scl_bus),
    .sda_i        (sda_bus),
    .cfg_own_addr (cfg_own_addr),
    .cfg_ten_bit  (cfg_ten_bit),
    .cfg_gc_en    (cfg_gc_en),
    .cfg_sw_recog (cfg_sw_recog),
    .cfg_nak      (cfg_nak),
    .ctl_wr       (ctl_wr),
    .scl_oe       (scl_oe),
    .sda_oe       (sda_oe),
    .addr_match   (addr_match),
    .gen_call     (gen_call),
    .rd_flag      (rd_flag),
    .rx_full      (rx_full),
    .rx_byte      (rx_byte),
    .irq          (irq)
  );

  int n_run  = 0;
  int n_fail = 0;
  int irq_cnt = 0;

  always @(posedge clk) if (irq === 1'b1) irq_cnt <= irq_cnt + 1;

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(input string req, input string what, input logic [31:0] act,
                     input logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic wait_scl_high;
    while (scl_bus !== 1'b1) @(negedge clk);
  endtask

  task automatic m_start;
    sda_m = 1'b1; tick(Q);
    scl_m = 1'b1; wait_scl_high; tick(Q);
    sda_m = 1'b0; tick(Q);
    scl_m = 1'b0; tick(Q);
  endtask

  task automatic m_stop;
    sda_m = 1'b0; tick(Q);
    scl_m = 1'b1; wait_scl_high; tick(Q);
    sda_m = 1'b1; tick(Q);
  endtask

  task automatic m_bit(input logic b, output logic r);
    sda_m = b; tick(Q);
    scl_m = 1'b1; wait_scl_high; tick(Q/2);
    r = sda_bus; tick(Q/2);
    scl_m = 1'b0; tick(Q);
  endtask

  task automatic m_bits(input logic [7:0] v);
    logic r;
    for (int i = 7; i >= 0; i--) m_bit(v[i], r);
  endtask

  task automatic m_byte(input logic [7:0] v, output logic a);
    m_bits(v);
    m_bit(1'b1, a);
  endtask

  task automatic host_write(input logic nak);
    cfg_nak = nak;
    ctl_wr = 1'b1; tick(1);
    ctl_wr = 1'b0; tick(2);
  endtask

  task automatic t_reset;
    chk("R1", "scl_oe after reset", scl_oe, 0);
    chk("R1", "sda_oe after reset", sda_oe, 0);
    chk("R1", "flags after reset", {addr_match, gen_call, rd_flag, rx_full, irq}, 0);
  endtask

  task automatic t_seven_bit;
    logic a;
    int base;
    base = irq_cnt;
    cfg_own_addr = 10'h05A; cfg_ten_bit = 0; cfg_nak = 0;
    m_start;
    m_byte(8'hB4, a);
    chk("R3", "7-bit ack", a, 0);
    chk("R3", "7-bit match", addr_match, 1);
    chk("R3", "7-bit rd", rd_flag, 0);
    chk("R3", "irq pulses", irq_cnt - base, 1);
    m_byte(8'hC3, a);
    chk("R11", "data ack", a, 0);
    chk("R11", "data rx_full", rx_full, 1);
    chk("R2", "msb first byte", rx_byte, 8'hC3);
    host_write(1'b0);
    chk("R11", "rx_full cleared", rx_full, 0);
    m_stop;
    chk("R1", "match held after stop", addr_match, 1);
    m_start;
    chk("R1", "match cleared by start", addr_match, 0);
    m_byte(8'hB5, a);
    chk("R3", "read ack", a, 0);
    chk("R3", "read rd flag", rd_flag, 1);
    m_stop;
    base = irq_cnt;
    m_byte(8'hB4, a);
    chk("R1", "no ack after stop", a, 1);
    chk("R1", "no irq after stop", irq_cnt - base, 0);
    m_stop;
  endtask

  task automatic t_nak;
    logic a;
    cfg_nak = 1;
    m_start;
    m_byte(8'hB4, a);
    chk("R4", "nak refuses", a, 1);
    chk("R4", "nak match flag", addr_match, 1);
    m_stop;
    cfg_nak = 0;
  endtask

  task automatic t_mismatch;
    logic a;
    int base;
    base = irq_cnt;
    m_start;
    m_byte(8'h22, a);
    chk("R5", "mismatch ack", a, 1);
    chk("R5", "mismatch match", addr_match, 0);
    m_byte(8'h00, a);
    chk("R5", "ignored data ack", a, 1);
    chk("R5", "ignored data rx_full", rx_full, 0);
    chk("R5", "no irq", irq_cnt - base, 0);
    m_stop;
  endtask

  task automatic t_ten_bit;
    logic a;
    cfg_ten_bit = 1; cfg_own_addr = 10'h2B5;
    m_start;
    m_byte(8'hF4, a);
    chk("R6", "header ack", a, 0);
    chk("R6", "header alone no match", addr_match, 0);
    m_byte(8'hB5, a);
    chk("R6", "low byte ack", a, 0);
    chk("R6", "10-bit match", addr_match, 1);
    m_byte(8'h5E, a);
    chk("R11", "10-bit data ack", a, 0);
    chk("R11", "10-bit data byte", rx_byte, 8'h5E);
    host_write(1'b0);
    m_start;
    chk("R7", "restart clears match", addr_match, 0);
    m_byte(8'hF5, a);
    chk("R7", "read header ack", a, 0);
    chk("R7", "read header match", addr_match, 1);
    chk("R7", "read header rd", rd_flag, 1);
    m_stop;
    m_start;
    m_byte(8'hF5, a);
    chk("R7", "read header after stop refused", a, 1);
    chk("R7", "read header after stop no match", addr_match, 0);
    m_stop;
    m_start;
    m_byte(8'hF2, a);
    chk("R6", "wrong header refused", a, 1);
    m_stop;
    m_start;
    m_byte(8'hF4, a);
    m_byte(8'hB4, a);
    chk("R6", "wrong low byte refused", a, 1);
    chk("R6", "wrong low byte no match", addr_match, 0);
    m_stop;
    cfg_gc_en = 1;
    m_start;
    m_byte(8'h00, a);
    chk("R8", "10-bit mode general call ack", a, 0);
    chk("R8", "10-bit mode general call flag", gen_call, 1);
    m_stop;
    cfg_gc_en = 0; cfg_ten_bit = 0; cfg_own_addr = 10'h05A;
  endtask

  task automatic t_gen_call;
    logic a;
    cfg_gc_en = 1;
    m_start;
    m_byte(8'h00, a);
    chk("R8", "general call ack", a, 0);
    chk("R8", "general call flags", {addr_match, gen_call, rd_flag}, 3'b110);
    cfg_sw_recog = 1;
    m_bits(8'h3C);
    tick(40);
    chk("R11", "stretch after gc data", {scl_oe, scl_bus}, 2'b10);
    chk("R11", "gc data byte", rx_byte, 8'h3C);
    host_write(1'b1);
    m_bit(1'b1, a);
    chk("R11", "host refused gc data", a, 1);
    chk("R11", "rx_full cleared by host", rx_full, 0);
    m_stop;
    cfg_sw_recog = 0; cfg_nak = 0; cfg_gc_en = 0;
    m_start;
    m_byte(8'h00, a);
    chk("R8", "gc disabled refused", a, 1);
    chk("R8", "gc disabled flags", {addr_match, gen_call}, 2'b00);
    m_stop;
  endtask

  task automatic t_start_byte;
    logic a;
    cfg_gc_en = 1; cfg_nak = 0;
    m_start;
    m_byte(8'h01, a);
    chk("R9", "start byte refused", a, 1);
    chk("R9", "start byte flags", {addr_match, gen_call, rd_flag}, 3'b111);
    m_stop;
    cfg_gc_en = 0;
  endtask

  task automatic t_sw_mode;
    logic a;
    cfg_sw_recog = 1;
    m_start;
    m_bits(8'hB4);
    tick(20);
    chk("R10", "scl held", scl_oe, 1);
    tick(100);
    chk("R10", "scl still low", scl_bus, 0);
    chk("R10", "rx_full", rx_full, 1);
    chk("R10", "rx_byte", rx_byte, 8'hB4);
    chk("R10", "no hw flags", {addr_match, gen_call, rd_flag}, 3'b000);
    host_write(1'b0);
    m_bit(1'b1, a);
    chk("R10", "host ack driven", a, 0);
    chk("R10", "rx_full cleared", rx_full, 0);
    m_bits(8'h77);
    tick(20);
    chk("R10", "second byte stretched", scl_oe, 1);
    chk("R10", "second byte value", rx_byte, 8'h77);
    host_write(1'b1);
    m_bit(1'b1, a);
    chk("R10", "host nak honoured", a, 1);
    m_stop;
    m_start;
    m_bits(8'h35);
    tick(20);
    chk("R10", "rd from first byte", rd_flag, 1);
    chk("R10", "no match in sw mode", addr_match, 0);
    host_write(1'b1);
    m_bit(1'b1, a);
    m_stop;
    cfg_sw_recog = 0; cfg_nak = 0;
  endtask

  task automatic t_restart_mid;
    logic a, r;
    m_start;
    m_bit(1'b1, r);
    m_bit(1'b0, r);
    m_bit(1'b1, r);
    m_start;
    m_byte(8'hB4, a);
    chk("R12", "restart mid byte ack", a, 0);
    chk("R12", "restart mid byte match", addr_match, 1);
    m_stop;
  endtask

  task automatic finish_run;
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_run++;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run;
  end

  initial begin
    rst_n = 0; scl_m = 1; sda_m = 1;
    cfg_own_addr = 10'h05A; cfg_ten_bit = 0; cfg_gc_en = 0;
    cfg_sw_recog = 0; cfg_nak = 0; ctl_wr = 0;
    tick(5);
    rst_n = 1;
    tick(5);
    t_reset;
    t_seven_bit;
    t_nak;
    t_mismatch;
    t_ten_bit;
    t_gen_call;
    t_start_byte;
    t_sw_mode;
    t_restart_mid;
    finish_run;
  end

endmodule